// File: doc/BRIEF.md
# DS3 Transmit Overhead Insertion Port

This block sits in the transmit path of a DS3 framer. External equipment uses it to overwrite single overhead bits of each outbound M-frame. The block walks an overhead-slot index across the 56 overhead positions of an M-frame. Each M-frame has seven 680-bit subframes, and each subframe holds eight overhead bits in the order X/P/M, F, C, F, C, F, C, F. Slot 0 is the first X bit and slot 8 is the second X bit. For every slot the block publishes a frame-start flag and a timing strobe. The external equipment may then supply a replacement value together with an insert request. The block emits the final bit for the slot, which is either the framer's own bit or the supplied one.

Each overhead slot lasts `SLOT_CYCLES` cycles of the line-rate transmit clock. Two timing methods can be selected:
- **Method 1:** a dedicated overhead clock. It is high for the first half of each slot, and the request and data are captured at its falling edge.
- **Method 2:** a one-cycle enable strobe on the transmit clock. The request and data are captured on the rising clock edge that ends the strobe.

The result leaves on a valid-only stream. The downstream framer runs at a fixed line rate and cannot stall, so this stream has no ready signal and accepts no back-pressure. One beat is produced per slot.

Top module: `ds3_oh_insert`

## Requirements
- R1: While reset is applied, `oh_clk_o`, `oh_en_o`, `frame_o` and `out_valid_o` are all 0. The first slot after reset release is index 0, with `frame_o` high.
- R2: The slot index advances by one per slot and wraps from 55 to 0. `frame_o` is high during slot 0 and low in every other slot. `out_idx_o` carries the index of the slot a result belongs to.
- R3: With `mode_i`=0 (method 1), `oh_clk_o` is high for the first `SLOT_CYCLES/2` clock cycles of each slot and low for the rest, and `oh_en_o` stays 0.
- R4: In method 1, the request and data are captured at the clock edge where `oh_clk_o` falls. `out_valid_o` is high in the cycle that follows.
- R5: With `mode_i`=1 (method 2), `oh_en_o` is high for exactly the first clock cycle of each slot and `oh_clk_o` stays 0. Capture happens on the edge that ends the enable cycle, and `out_valid_o` is high in the next cycle.
- R6: If the captured `oh_ins_i` is 1, `out_bit_o` equals the captured `oh_data_i`. If it is 0, `out_bit_o` equals the captured `base_bit_i` and `oh_data_i` has no effect.
- R7: `out_valid_o` is a single-cycle pulse, exactly once per slot.
- R8: A reset sampled on a capture edge cancels that capture, so no `out_valid_o` pulse follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-rate transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 0: overhead clock method, 1: enable strobe method |
| base_bit_i | input | 1 | Framer-generated overhead bit for the current slot |
| oh_ins_i | input | 1 | Insert request from external equipment |
| oh_data_i | input | 1 | Replacement overhead bit |
| oh_clk_o | output | 1 | Dedicated overhead clock (method 1) |
| oh_en_o | output | 1 | Slot enable strobe (method 2) |
| frame_o | output | 1 | High during slot 0 of the M-frame |
| out_valid_o | output | 1 | Result beat valid |
| out_idx_o | output | 6 | Slot index of the result beat |
| out_bit_o | output | 1 | Overhead bit to transmit |

## Verification
Two events can land on the same clock edge: an insertion capture and a reset. In method 2 the bench raises the insert request and reset together in the enable cycle. It then judges that no result beat follows, that all strobes drop, and that the next slot restarts at index 0 with frame start. A second overlap is the capture for slot 55 next to the index wrap. The bench judges this by inserting on slot 55 and on the following slot 0, then checking both indices, `frame_o`, and both output bits.

// File: rtl/ds3oh_pkg.sv
package ds3oh_pkg;
  typedef enum logic {
    MODE_OHCLK = 1'b0,
    MODE_TXEN  = 1'b1
  } oh_mode_e;
endpackage

// File: rtl/ds3oh_slot_timer.sv
module ds3oh_slot_timer #(
  parameter int SLOT_CYCLES = 8,
  parameter int NUM_SLOTS   = 56,
  localparam int PH_W  = $clog2(SLOT_CYCLES),
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  output logic             run_o,
  output logic [PH_W-1:0]  phase_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(SLOT_CYCLES - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_SLOTS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_o   <= 1'b0;
      phase_o <= '0;
      idx_o   <= '0;
    end else begin
      run_o <= 1'b1;
      if (run_o) begin
        if (phase_o == PH_LAST) begin
          phase_o <= '0;
          idx_o   <= (idx_o == IDX_LAST) ? '0 : idx_o + 1'b1;
        end else begin
          phase_o <= phase_o + 1'b1;
        end
      end
    end
  end

  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    idx_o <= IDX_LAST);

  // R2
  idx_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (run_o && phase_o == PH_LAST && idx_o == IDX_LAST) |=> (idx_o == '0));
endmodule

// File: rtl/ds3oh_strobes.sv
module ds3oh_strobes
  import ds3oh_pkg::*;
#(
  parameter int SLOT_CYCLES = 8,
  parameter int NUM_SLOTS   = 56,
  localparam int PH_W  = $clog2(SLOT_CYCLES),
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  oh_mode_e         mode_i,
  input  logic [PH_W-1:0]  phase_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             oh_clk_o,
  output logic             oh_en_o,
  output logic             frame_o,
  output logic             sample_o
);
  localparam logic [PH_W-1:0] PH_HALF   = PH_W'(SLOT_CYCLES / 2);
  localparam logic [PH_W-1:0] PH_FALL_M = PH_W'(SLOT_CYCLES / 2 - 1);

  logic cap_m1, cap_m2;

  always_comb begin
    oh_clk_o = run_i && (mode_i == MODE_OHCLK) && (phase_i < PH_HALF);
    oh_en_o  = run_i && (mode_i == MODE_TXEN) && (phase_i == '0);
    frame_o  = run_i && (idx_i == '0);
    cap_m1   = (mode_i == MODE_OHCLK) && (phase_i == PH_FALL_M);
    cap_m2   = (mode_i == MODE_TXEN) && (phase_i == '0);
    sample_o = run_i && (cap_m1 || cap_m2);
  end

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(oh_clk_o && oh_en_o));

  // R5
  en_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    oh_en_o |=> !oh_en_o);
endmodule

// File: rtl/ds3oh_insert_mux.sv
module ds3oh_insert_mux #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sample_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             ins_i,
  input  logic             data_i,
  input  logic             base_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             bit_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      idx_o   <= '0;
      bit_o   <= 1'b0;
    end else begin
      valid_o <= sample_i;
      if (sample_i) begin
        idx_o <= idx_i;
        bit_o <= ins_i ? data_i : base_i;
      end
    end
  end

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R6
  ins_pick_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (bit_o == ($past(ins_i) ? $past(data_i) : $past(base_i))));

  // R8
  reset_cancel_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !valid_o);
endmodule

// File: rtl/ds3_oh_insert.sv
module ds3_oh_insert
  import ds3oh_pkg::*;
#(
  parameter int SLOT_CYCLES = 8,
  parameter int NUM_SLOTS   = 56,
  localparam int PH_W  = $clog2(SLOT_CYCLES),
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_i,
  input  logic             base_bit_i,
  input  logic             oh_ins_i,
  input  logic             oh_data_i,
  output logic             oh_clk_o,
  output logic             oh_en_o,
  output logic             frame_o,
  output logic             out_valid_o,
  output logic [IDX_W-1:0] out_idx_o,
  output logic             out_bit_o
);
  oh_mode_e         mode;
  logic             run;
  logic [PH_W-1:0]  phase;
  logic [IDX_W-1:0] idx;
  logic             sample;

  assign mode = oh_mode_e'(mode_i);

  ds3oh_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES), .NUM_SLOTS(NUM_SLOTS)) u_timer (
    .clk(clk), .rst(rst), .run_o(run), .phase_o(phase), .idx_o(idx)
  );

  ds3oh_strobes #(.SLOT_CYCLES(SLOT_CYCLES), .NUM_SLOTS(NUM_SLOTS)) u_strobes (
    .clk(clk), .rst(rst), .run_i(run), .mode_i(mode), .phase_i(phase),
    .idx_i(idx), .oh_clk_o(oh_clk_o), .oh_en_o(oh_en_o), .frame_o(frame_o),
    .sample_o(sample)
  );

  ds3oh_insert_mux #(.IDX_W(IDX_W)) u_mux (
    .clk(clk), .rst(rst), .sample_i(sample), .idx_i(idx), .ins_i(oh_ins_i),
    .data_i(oh_data_i), .base_i(base_bit_i), .valid_o(out_valid_o),
    .idx_o(out_idx_o), .bit_o(out_bit_o)
  );

  // R2
  frame_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && frame_o) |-> (out_idx_o == '0));
endmodule

// File: tb/ds3_oh_insert_test.sv
`timescale 1ns/1ps
module ds3_oh_insert_test;
  localparam int SLOT_CYCLES = 8;
  localparam int NUM_SLOTS   = 56;
  localparam int HALF        = SLOT_CYCLES / 2;

  // {mode, ins, data, base, expected bit}
  localparam logic [4:0] VEC [8] = '{
    5'b1_1_0_1_0, 5'b1_1_1_0_1, 5'b1_0_0_1_1, 5'b1_0_1_0_0,
    5'b0_1_0_1_0, 5'b0_0_1_0_0, 5'b0_1_1_1_1, 5'b0_0_0_1_1
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_i = 1'b1, base_bit_i = 1'b0, oh_ins_i = 1'b0, oh_data_i = 1'b0;
  logic oh_clk_o, oh_en_o, frame_o, out_valid_o, out_bit_o;
  logic [5:0] out_idx_o;

  int n_cmp = 0;
  int n_bad = 0;
  int slot = -1;
  logic last_ohclk = 1'b0;

  always #4 clk = ~clk;

  ds3_oh_insert #(.SLOT_CYCLES(SLOT_CYCLES), .NUM_SLOTS(NUM_SLOTS)) uut (
    .clk(clk), .rst(rst), .mode_i(mode_i), .base_bit_i(base_bit_i),
    .oh_ins_i(oh_ins_i), .oh_data_i(oh_data_i), .oh_clk_o(oh_clk_o),
    .oh_en_o(oh_en_o), .frame_o(frame_o), .out_valid_o(out_valid_o),
    .out_idx_o(out_idx_o), .out_bit_o(out_bit_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (slot %0d)", req, act, exp, slot);
    end
  endtask

  task automatic nclk();
    last_ohclk = oh_clk_o;
    @(negedge clk);
  endtask

  task automatic do_reset(input logic m);
    nclk();
    rst = 1'b1; oh_ins_i = 1'b0; mode_i = m;
    nclk(); nclk();
    chk("R1 oh_clk in reset", oh_clk_o, 0);
    chk("R1 oh_en in reset", oh_en_o, 0);
    chk("R1 frame in reset", frame_o, 0);
    chk("R1 valid in reset", out_valid_o, 0);
    rst = 1'b0;
    slot = -1;
    last_ohclk = 1'b0;
  endtask

  task automatic wait_strobe();
    for (int g = 0; g < 4 * SLOT_CYCLES; g++) begin
      if (mode_i ? oh_en_o : (oh_clk_o && !last_ohclk)) return;
      nclk();
    end
    chk("strobe timeout", 1, 0);
  endtask

  task automatic run_slot(input logic ins_v, input logic data_v,
                          input logic base_v, input logic exp_bit);
    int lat;
    wait_strobe();
    slot = (slot + 1) % NUM_SLOTS;
    chk("R2 frame flag", frame_o, (slot == 0) ? 1 : 0);
    if (mode_i) chk("R5 overhead clock idle", oh_clk_o, 0);
    else        chk("R3 enable idle", oh_en_o, 0);
    oh_ins_i = ins_v; oh_data_i = data_v; base_bit_i = base_v;
    lat = mode_i ? 1 : HALF;
    for (int k = 1; k <= lat; k++) begin
      nclk();
      if (k < lat) begin
        chk("R4 no early valid", out_valid_o, 0);
        chk("R3 overhead clock high half", oh_clk_o, 1);
      end
    end
    if (mode_i) begin
      chk("R5 enable one cycle", oh_en_o, 0);
      chk("R5 valid after enable", out_valid_o, 1);
    end else begin
      chk("R3 overhead clock falls", oh_clk_o, 0);
      chk("R4 valid after fall", out_valid_o, 1);
    end
    chk("R2 result index", out_idx_o, slot);
    chk("R6 result bit", out_bit_o, exp_bit);
    oh_ins_i = 1'b0; oh_data_i = ~data_v;
    nclk();
    chk("R7 single pulse", out_valid_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic cur_mode;
    logic ins_b;
    do_reset(1'b1);
    cur_mode = 1'b1;

    // Vector table: mode, insert, data, base, expected bit
    for (int v = 0; v < 8; v++) begin
      if (VEC[v][4] != cur_mode) begin
        cur_mode = VEC[v][4];
        do_reset(cur_mode);
      end
      run_slot(VEC[v][3], VEC[v][2], VEC[v][1], VEC[v][0]);
    end

    // R6: both X bits (slots 0 and 8) forced to 0 in method 1, then wrap (R2)
    do_reset(1'b0);
    for (int s = 0; s <= NUM_SLOTS; s++) begin
      ins_b = (s == 0 || s == 8 || s == NUM_SLOTS);
      run_slot(ins_b, 1'b0, 1'b1, ins_b ? 1'b0 : 1'b1);
    end

    // R2: insertion on slot 55 next to the wrap, method 2
    do_reset(1'b1);
    for (int s = 0; s <= NUM_SLOTS; s++) begin
      ins_b = (s == NUM_SLOTS - 1 || s == NUM_SLOTS);
      run_slot(ins_b, s[0], ~s[0], ins_b ? s[0] : ~s[0]);
    end

    // R8: reset lands on the capture edge
    do_reset(1'b1);
    for (int s = 0; s < 3; s++) run_slot(1'b0, 1'b1, 1'b0, 1'b0);
    wait_strobe();
    oh_ins_i = 1'b1; oh_data_i = 1'b1; rst = 1'b1;
    nclk();
    chk("R8 capture cancelled", out_valid_o, 0);
    chk("R1 enable low in reset", oh_en_o, 0);
    chk("R1 frame low in reset", frame_o, 0);
    oh_ins_i = 1'b0;
    rst = 1'b0; slot = -1;
    run_slot(1'b0, 1'b0, 1'b1, 1'b1);
    chk("R1 restart at index 0", out_idx_o, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule